// File: doc/BRIEF.md
# E1 Demux Timing and Alarm-Insertion Controller

This block sits on the E1-facing demux side of a three-loop line framer. An 8-bit control register sets its behaviour. The first function picks the E1 output clock. It can use one of the three recovered loop clocks or a nominal local clock, and the choice is either forced by software or made automatically from per-loop sync-loss pins and a software loop-enable mask. A change of source takes effect only while both the old and the new source are low, so the output never shows a shortened pulse.

The block also replaces per-loop demux payload words with all ones (alarm indication) when told to. The order can come from a register bit, or from a loop's sync-loss pin when external insertion is enabled. The serial E1 data and frame mark are re-timed so that they change on the rising or on the falling edge of the output clock. A loopback mode sends the E1 clock, data and frame mark back in both directions.

Each loop's payload travels as a valid/ready stream. The block only rewrites the data word. `pay_ready_o[i]` follows `pay_ready_i[i]` and `pay_valid_o[i]` follows `pay_valid_i[i]` in the same cycle. A beat transfers when valid and ready are both high, and the block neither stores nor drops beats. The recovered clocks are sampled levels in the `clk` domain, and the output clock is a registered copy of the selected level.

Top module: `e1_demux_ctl`

## Requirements
- R1: After reset the control register reads 0x01: edge-invert bit 7, loopback bit 6, source code bits 5:4 and alarm bits 3:1 are all low, and external-alarm enable bit 0 is high.
- R2: A write with `cfg_we` high stores `cfg_wdata`, and it reads back on `cfg_rdata` from the next clock.
- R3: With source code 00, the output clock follows the lowest-numbered loop whose sync-loss pin (`los_i[0]` = loop 1) is low and whose `lp_en_i` bit is high. If no loop qualifies, it follows `nom_clk_i`.
- R4: Source codes 01, 10 and 11 make the output clock follow loop 1, 2 and 3 regardless of the sync-loss pins and the mask.
- R5: A new source is adopted only in a cycle where the registered output clock is low and both the old and the new source levels are low. Until then, the output keeps following the old source.
- R6: With bit 7 low, `e1_data_o` and `e1_fm_o` change only when `e1_clk_o` rises. With bit 7 high, they change only when it falls. Each takes the value of `dmx_data_i`/`dmx_fm_i` present at that edge.
- R7: When alarm bit 1+i is high (bit 1 = loop 1, bit 3 = loop 3), `pay_data_o[i]` is all ones.
- R8: When bit 0 is high, `los_i[i]` high forces `pay_data_o[i]` to all ones. When bit 0 is low, `los_i` does not affect the payload.
- R9: With bit 6 high, `e1_clk_o`/`e1_data_o`/`e1_fm_o` equal the `e1_tx_*` inputs, and `mx_*` carry the re-timed demux clock, data and frame mark. With bit 6 low, `mx_*` equal `e1_tx_*`.
- R10: With no alarm forcing, `pay_data_o[i]` equals `pay_data_i[i]`. Valid and ready pass through unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| lp_en_i | input | 3 | Software loop-enable mask for automatic selection |
| los_i | input | 3 | Per-loop sync-loss indications |
| lp_clk_i | input | 3 | Recovered loop clock levels |
| nom_clk_i | input | 1 | Nominal local clock level |
| dmx_data_i | input | 1 | Demux serial E1 data |
| dmx_fm_i | input | 1 | Demux frame mark |
| e1_tx_clk_i | input | 1 | E1 clock from the framer side |
| e1_tx_data_i | input | 1 | E1 data from the framer side |
| e1_tx_fm_i | input | 1 | E1 frame mark from the framer side |
| e1_clk_o | output | 1 | E1 output clock |
| e1_data_o | output | 1 | E1 output data |
| e1_fm_o | output | 1 | E1 output frame mark |
| mx_clk_o | output | 1 | Clock toward the mux side |
| mx_data_o | output | 1 | Data toward the mux side |
| mx_fm_o | output | 1 | Frame mark toward the mux side |
| pay_valid_i | input | 3 | Per-loop payload valid in |
| pay_data_i | input | 3x8 | Per-loop payload words in |
| pay_ready_o | output | 3 | Per-loop ready back to the source |
| pay_valid_o | output | 3 | Per-loop payload valid out |
| pay_data_o | output | 3x8 | Per-loop payload words out |
| pay_ready_i | input | 3 | Per-loop ready from the sink |

## Verification
The bench sweeps automatic selection over sync-loss and mask patterns, including loops that are lost but unmasked and loops that are masked but not lost. It also covers the all-lost fallback and each forced code. A priority error would show up as the wrong clock following a one-hot level pattern.

The clock-switch test changes the source while the old clock is high and while the new clock is high. A design that switches eagerly would drop the output low or raise it early.

The edge tests move data between clock edges under both polarities, which exposes re-timing on the wrong edge. The alarm tests separate register-driven forcing from pin-driven forcing, including pins that are active while external insertion is disabled.

// File: rtl/e1dx_pkg.sv
package e1dx_pkg;
  typedef struct packed {
    logic       inv;   // [7] data/frame mark on falling edge
    logic       lb;    // [6] loopback
    logic [1:0] tsrc;  // [5:4] timing source code
    logic [2:0] ais;   // [3:1] per-loop forced alarm, [1] = loop 1
    logic       ext;   // [0] sync-loss pins drive the alarm
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h01;
endpackage

// File: rtl/e1dx_tsel.sv
module e1dx_tsel #(
  parameter int N = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tsrc,
  input  logic [N-1:0] los,
  input  logic [N-1:0] en,
  input  logic [N-1:0] lp_clk,
  input  logic       nom_clk,
  output logic       clk_q,
  output logic       rise_nx,
  output logic       fall_nx
);
  localparam int SW = $clog2(N + 1);

  logic [N:0]    lvl;
  logic [SW-1:0] want;
  logic [SW-1:0] sel_q;
  logic          cur;
  logic          nxt;

  assign lvl = {lp_clk, nom_clk};

  // Source index 0 is the nominal clock; index i+1 is loop i+1.
  always_comb begin
    want = '0;
    if (tsrc != 2'b00) begin
      want = SW'(tsrc);
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!los[i] && en[i]) want = SW'(i + 1);
      end
    end
  end

  assign cur = lvl[sel_q];
  assign nxt = lvl[want];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      clk_q <= 1'b0;
    end else begin
      clk_q <= cur;
      if (want != sel_q && !clk_q && !cur && !nxt) sel_q <= want;
    end
  end

  assign rise_nx = cur & ~clk_q;
  assign fall_nx = ~cur & clk_q;
endmodule

// File: rtl/e1dx_ais.sv
module e1dx_ais #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N-1:0]        ais,
  input  logic                ext,
  input  logic [N-1:0]        los,
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic [N-1:0]        ready_o,
  output logic [N-1:0]        valid_o,
  output logic [N-1:0][W-1:0] data_o,
  input  logic [N-1:0]        ready_i
);
  for (genvar i = 0; i < N; i++) begin : g_lp
    logic force_ones;
    assign force_ones = ais[i] | (ext & los[i]);
    assign data_o[i]  = force_ones ? {W{1'b1}} : data_i[i];
    assign valid_o[i] = valid_i[i];
    assign ready_o[i] = ready_i[i];
  end
endmodule

// File: rtl/e1dx_out.sv
module e1dx_out (
  input  logic clk,
  input  logic rst_n,
  input  logic inv,
  input  logic lb,
  input  logic clk_q,
  input  logic rise_nx,
  input  logic fall_nx,
  input  logic dmx_data,
  input  logic dmx_fm,
  input  logic tx_clk,
  input  logic tx_data,
  input  logic tx_fm,
  output logic e1_clk,
  output logic e1_data,
  output logic e1_fm,
  output logic mx_clk,
  output logic mx_data,
  output logic mx_fm
);
  logic data_q;
  logic fm_q;
  logic take;

  assign take = inv ? fall_nx : rise_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      fm_q   <= 1'b0;
    end else if (take) begin
      data_q <= dmx_data;
      fm_q   <= dmx_fm;
    end
  end

  assign e1_clk  = lb ? tx_clk  : clk_q;
  assign e1_data = lb ? tx_data : data_q;
  assign e1_fm   = lb ? tx_fm   : fm_q;
  assign mx_clk  = lb ? clk_q   : tx_clk;
  assign mx_data = lb ? data_q  : tx_data;
  assign mx_fm   = lb ? fm_q    : tx_fm;
endmodule

// File: rtl/e1_demux_ctl.sv
module e1_demux_ctl
  import e1dx_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [N-1:0]        lp_en_i,
  input  logic [N-1:0]        los_i,
  input  logic [N-1:0]        lp_clk_i,
  input  logic                nom_clk_i,
  input  logic                dmx_data_i,
  input  logic                dmx_fm_i,
  input  logic                e1_tx_clk_i,
  input  logic                e1_tx_data_i,
  input  logic                e1_tx_fm_i,
  output logic                e1_clk_o,
  output logic                e1_data_o,
  output logic                e1_fm_o,
  output logic                mx_clk_o,
  output logic                mx_data_o,
  output logic                mx_fm_o,
  input  logic [N-1:0]        pay_valid_i,
  input  logic [N-1:0][W-1:0] pay_data_i,
  output logic [N-1:0]        pay_ready_o,
  output logic [N-1:0]        pay_valid_o,
  output logic [N-1:0][W-1:0] pay_data_o,
  input  logic [N-1:0]        pay_ready_i
);
  ctl_t ctl_q;
  logic clk_q, rise_nx, fall_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= ctl_t'(CTL_RESET);
    else if (cfg_we) ctl_q <= ctl_t'(cfg_wdata);
  end

  assign cfg_rdata = ctl_q;

  e1dx_tsel #(.N(N)) u_tsel (
    .clk(clk), .rst_n(rst_n), .tsrc(ctl_q.tsrc), .los(los_i), .en(lp_en_i),
    .lp_clk(lp_clk_i), .nom_clk(nom_clk_i),
    .clk_q(clk_q), .rise_nx(rise_nx), .fall_nx(fall_nx)
  );

  e1dx_ais #(.N(N), .W(W)) u_ais (
    .ais(ctl_q.ais[N-1:0]), .ext(ctl_q.ext), .los(los_i),
    .valid_i(pay_valid_i), .data_i(pay_data_i), .ready_o(pay_ready_o),
    .valid_o(pay_valid_o), .data_o(pay_data_o), .ready_i(pay_ready_i)
  );

  e1dx_out u_out (
    .clk(clk), .rst_n(rst_n), .inv(ctl_q.inv), .lb(ctl_q.lb),
    .clk_q(clk_q), .rise_nx(rise_nx), .fall_nx(fall_nx),
    .dmx_data(dmx_data_i), .dmx_fm(dmx_fm_i),
    .tx_clk(e1_tx_clk_i), .tx_data(e1_tx_data_i), .tx_fm(e1_tx_fm_i),
    .e1_clk(e1_clk_o), .e1_data(e1_data_o), .e1_fm(e1_fm_o),
    .mx_clk(mx_clk_o), .mx_data(mx_data_o), .mx_fm(mx_fm_o)
  );
endmodule

// File: rtl/e1dx_chk.sv
module e1dx_chk #(
  parameter int N = 3,
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [7:0]          cfg_wdata,
  input logic [7:0]          cfg_rdata,
  input logic [N-1:0]        los_i,
  input logic                e1_tx_clk_i,
  input logic                e1_tx_data_i,
  input logic                e1_tx_fm_i,
  input logic                e1_clk_o,
  input logic                e1_data_o,
  input logic                e1_fm_o,
  input logic                mx_clk_o,
  input logic                mx_data_o,
  input logic                mx_fm_o,
  input logic [N-1:0]        pay_valid_i,
  input logic [N-1:0][W-1:0] pay_data_i,
  input logic [N-1:0]        pay_ready_i,
  input logic [N-1:0]        pay_valid_o,
  input logic [N-1:0][W-1:0] pay_data_o,
  input logic [N-1:0]        pay_ready_o
);
  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> cfg_rdata == 8'h01);

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  assert_quiet_between_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[6] && $stable(cfg_rdata) && $stable(e1_clk_o)
    |-> $stable(e1_data_o) && $stable(e1_fm_o));

  assert_no_fall_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[6] && !cfg_rdata[7] && $stable(cfg_rdata) && $fell(e1_clk_o)
    |-> $stable(e1_data_o) && $stable(e1_fm_o));

  assert_loop_e1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |-> e1_clk_o == e1_tx_clk_i && e1_data_o == e1_tx_data_i
                     && e1_fm_o == e1_tx_fm_i);

  assert_normal_mx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[6] |-> mx_clk_o == e1_tx_clk_i && mx_data_o == e1_tx_data_i
                      && mx_fm_o == e1_tx_fm_i);

  assert_stream_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready_o == pay_ready_i && pay_valid_o == pay_valid_i);

  for (genvar i = 0; i < N; i++) begin : g_lp
    assert_reg_ais_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[i+1] |-> pay_data_o[i] == {W{1'b1}});
    assert_pin_ais_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[0] && los_i[i] |-> pay_data_o[i] == {W{1'b1}});
    assert_payload_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[i+1] && !(cfg_rdata[0] && los_i[i]) |-> pay_data_o[i] == pay_data_i[i]);
  end
endmodule

bind e1_demux_ctl e1dx_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .los_i(los_i),
  .e1_tx_clk_i(e1_tx_clk_i), .e1_tx_data_i(e1_tx_data_i), .e1_tx_fm_i(e1_tx_fm_i),
  .e1_clk_o(e1_clk_o), .e1_data_o(e1_data_o), .e1_fm_o(e1_fm_o),
  .mx_clk_o(mx_clk_o), .mx_data_o(mx_data_o), .mx_fm_o(mx_fm_o),
  .pay_valid_i(pay_valid_i), .pay_data_i(pay_data_i), .pay_ready_i(pay_ready_i),
  .pay_valid_o(pay_valid_o), .pay_data_o(pay_data_o), .pay_ready_o(pay_ready_o)
);

// File: tb/sim_e1_demux_ctl.sv
`timescale 1ns/1ps
module sim_e1_demux_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [2:0] lp_en_i = 3'b111;
  logic [2:0] los_i = 3'b000;
  logic [3:0] lv = 4'b0000;  // {loop3, loop2, loop1, nominal}
  logic dmx_data_i = 1'b0, dmx_fm_i = 1'b0;
  logic e1_tx_clk_i = 1'b0, e1_tx_data_i = 1'b0, e1_tx_fm_i = 1'b0;
  logic e1_clk_o, e1_data_o, e1_fm_o, mx_clk_o, mx_data_o, mx_fm_o;
  logic [2:0] pay_valid_i = 3'b011, pay_ready_i = 3'b101;
  logic [2:0][7:0] pay_data_i = {8'h33, 8'h22, 8'h11};
  logic [2:0] pay_ready_o, pay_valid_o;
  logic [2:0][7:0] pay_data_o;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  e1_demux_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lp_en_i(lp_en_i), .los_i(los_i),
    .lp_clk_i(lv[3:1]), .nom_clk_i(lv[0]),
    .dmx_data_i(dmx_data_i), .dmx_fm_i(dmx_fm_i),
    .e1_tx_clk_i(e1_tx_clk_i), .e1_tx_data_i(e1_tx_data_i), .e1_tx_fm_i(e1_tx_fm_i),
    .e1_clk_o(e1_clk_o), .e1_data_o(e1_data_o), .e1_fm_o(e1_fm_o),
    .mx_clk_o(mx_clk_o), .mx_data_o(mx_data_o), .mx_fm_o(mx_fm_o),
    .pay_valid_i(pay_valid_i), .pay_data_i(pay_data_i), .pay_ready_o(pay_ready_o),
    .pay_valid_o(pay_valid_o), .pay_data_o(pay_data_o), .pay_ready_i(pay_ready_i)
  );

  // {code[1:0], los[2:0], mask[2:0], expected source[1:0]}; source 0 = nominal
  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 3'b000, 3'b111, 2'd1}, {2'd0, 3'b001, 3'b111, 2'd2},
    {2'd0, 3'b011, 3'b111, 2'd3}, {2'd0, 3'b111, 3'b111, 2'd0},
    {2'd0, 3'b101, 3'b111, 2'd2}, {2'd0, 3'b110, 3'b111, 2'd1},
    {2'd0, 3'b010, 3'b111, 2'd1}, {2'd0, 3'b000, 3'b110, 2'd2},
    {2'd0, 3'b000, 3'b100, 2'd3}, {2'd0, 3'b000, 3'b000, 2'd0},
    {2'd0, 3'b100, 3'b011, 2'd1}, {2'd1, 3'b111, 3'b000, 2'd1},
    {2'd2, 3'b000, 3'b111, 2'd2}, {2'd3, 3'b011, 3'b111, 2'd3},
    {2'd1, 3'b001, 3'b111, 2'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    check("R1 reset value", cfg_rdata, 8'h01);
    check("R10 ready pass", pay_ready_o, 3'b101);
    check("R10 valid pass", pay_valid_o, 3'b011);
    check("R10 data pass", pay_data_o, {8'h33, 8'h22, 8'h11});

    los_i = 3'b010;  // external enable is set by reset
    wait_n(1);
    check("R8 pin forces loop 2", pay_data_o, {8'h33, 8'hFF, 8'h11});
    wr(8'h00);
    check("R8 pins ignored when disabled", pay_data_o, {8'h33, 8'h22, 8'h11});
    wr(8'h08);
    check("R7 loop 3 forced", pay_data_o, {8'hFF, 8'h22, 8'h11});
    wr(8'h02);
    check("R7 loop 1 forced", pay_data_o, {8'h33, 8'h22, 8'hFF});
    wr(8'hA5);
    check("R2 readback", cfg_rdata, 8'hA5);
    wr(8'h00);
    los_i = 3'b000;

    // R3 / R4 table sweep
    for (int k = 0; k < NV; k++) begin
      logic [1:0] code, src;
      code = VEC[k][9:8];
      los_i = VEC[k][7:5];
      lp_en_i = VEC[k][4:2];
      src = VEC[k][1:0];
      lv = 4'b0000;
      wr({2'b00, code, 4'b0000});
      wait_n(3);
      lv = 4'b0001 << src;
      wait_n(2);
      check(code == 2'd0 ? "R3 auto select high" : "R4 forced select high", e1_clk_o, 1'b1);
      lv = ~(4'b0001 << src);
      wait_n(2);
      check(code == 2'd0 ? "R3 auto select low" : "R4 forced select low", e1_clk_o, 1'b0);
    end
    lv = 4'b0000;
    los_i = 3'b000;
    lp_en_i = 3'b111;

    // R5 glitch-free switch
    wr(8'h10);
    wait_n(3);
    lv = 4'b0010;
    wait_n(2);
    check("R5 on loop 1", e1_clk_o, 1'b1);
    wr(8'h20);
    wait_n(3);
    check("R5 held while old high", e1_clk_o, 1'b1);
    lv = 4'b0100;
    wait_n(3);
    check("R5 held while new high", e1_clk_o, 1'b0);
    lv = 4'b0000;
    wait_n(3);
    lv = 4'b0100;
    wait_n(2);
    check("R5 switched to loop 2", e1_clk_o, 1'b1);
    lv = 4'b0010;
    wait_n(2);
    check("R5 loop 1 no longer seen", e1_clk_o, 1'b0);
    lv = 4'b0000;

    // R6 edge alignment
    wr(8'h10);
    wait_n(3);
    check("R6 data idle", e1_data_o, 1'b0);
    dmx_data_i = 1'b1;
    dmx_fm_i = 1'b1;
    wait_n(2);
    check("R6 no update without edge", e1_data_o, 1'b0);
    lv = 4'b0010;
    wait_n(1);
    check("R6 rising update clk", e1_clk_o, 1'b1);
    check("R6 rising update data", e1_data_o, 1'b1);
    check("R6 rising update fm", e1_fm_o, 1'b1);
    dmx_data_i = 1'b0;
    dmx_fm_i = 1'b0;
    lv = 4'b0000;
    wait_n(2);
    check("R6 falling ignored", e1_data_o, 1'b1);
    wr(8'h90);
    lv = 4'b0010;
    wait_n(2);
    check("R6 inverted rising ignored", e1_data_o, 1'b1);
    lv = 4'b0000;
    wait_n(2);
    check("R6 inverted falling update", e1_data_o, 1'b0);
    check("R6 inverted falling fm", e1_fm_o, 1'b0);

    // R9 loopback
    wr(8'h50);
    e1_tx_clk_i = 1'b1;
    e1_tx_data_i = 1'b1;
    e1_tx_fm_i = 1'b1;
    lv = 4'b0010;
    wait_n(2);
    check("R9 loop e1 clk", e1_clk_o, 1'b1);
    check("R9 loop e1 data", e1_data_o, 1'b1);
    check("R9 loop mx clk", mx_clk_o, 1'b1);
    e1_tx_clk_i = 1'b0;
    wait_n(1);
    check("R9 loop e1 clk follows tx", e1_clk_o, 1'b0);
    wr(8'h10);
    wait_n(1);
    check("R9 normal e1 clk", e1_clk_o, 1'b1);
    check("R9 normal mx clk", mx_clk_o, 1'b0);
    check("R9 normal mx data", mx_data_o, 1'b1);
    check("R9 normal mx fm", mx_fm_o, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule